// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the refresh duty of an EDO DRAM channel. Out of reset it holds off every memory cycle for a programmable start-up wait. It then asks the access arbiter for a fixed number of wake-up refresh slots and raises an init-complete flag once the last one has finished. From then on, a free-running interval timer creates one refresh obligation per period, so that all rows are covered within the retention window.

Each refresh is a CAS-before-RAS cycle that the block drives itself. The device supplies the row from its internal counter, so the block drives no address or data. The request and grant pins form a valid/ready pair. The request stays high while a refresh is owed and no strobe sequence is running. A refresh starts on the first cycle in which request and grant are both high. A grant sampled while the request is low does nothing. The arbiter may hold back the grant for as long as it likes. Meanwhile the timer keeps running and further obligations are queued, up to a limit. One obligation beyond the limit sets a sticky overrun flag.

All timing values are clock-cycle parameters: start-up wait, wake-up count, refresh period, queue depth, CAS-to-RAS setup, CAS hold after RAS, RAS low width and RAS precharge.

Top module: `rfs_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, ras_n, cas_n and we_n are 1 and ref_req, ref_done, init_done and overrun are 0.
- R2: ref_req stays 0 for the first INIT_WAIT-1 rising edges after reset is released and reads 1 after edge number INIT_WAIT.
- R3: A ref_grant sampled while ref_req is 0 starts no strobe activity: ras_n and cas_n stay 1.
- R4: A grant accepted at edge g gives this sequence. cas_n is 0 with ras_n at 1 for T_CSR cycles. Then both are 0 for T_CHR cycles. Then ras_n alone is 0 until its low time totals T_RAS cycles. Then both are 1 for T_RP cycles. ref_done is then 1 for exactly one cycle. we_n is 1 throughout.
- R5: ref_req is 0 from the accepting edge until ref_done has fallen, and a grant given during a running sequence starts no second sequence.
- R6: init_done rises on the edge that ends the ref_done pulse of the INIT_REFRESHES-th wake-up refresh and never falls afterwards.
- R7: The k-th periodic request appears REF_INTERVAL*k edges after init_done rose, no matter how late earlier grants came.
- R8: Up to OWED_MAX unserved obligations are kept, and they are served back to back with ref_req high again one cycle after each ref_done.
- R9: A period that expires while OWED_MAX obligations are pending sets overrun on that edge, adds no obligation, and overrun stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_grant | input | 1 | Arbiter grant (ready); given only with RAS high |
| ref_req | output | 1 | Refresh request (valid) |
| ref_done | output | 1 | One-cycle pulse at the end of a refresh |
| init_done | output | 1 | Start-up wait and wake-up refreshes complete |
| overrun | output | 1 | Sticky: an obligation was lost |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, held high |

## Verification
The bench uses a small configuration and serves requests with several grant patterns. Wake-up grants come after zero, one or two idle cycles, which separates a request that waits from one that is dropped. A grant is held back for most of a period, which shows whether the interval timer restarts on a grant or runs freely. Grants are withheld across several periods to fill the queue and then one period more, which separates saturation from overrun. Every served refresh is compared cycle by cycle with the strobe shape computed from the timing parameters. Stray grants with no request, and grants given during a running sequence, show whether unsolicited grants are ignored.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {PH_WAIT, PH_WAKE, PH_RUN} phase_t;
  typedef enum logic [2:0] {SQ_IDLE, SQ_SETUP, SQ_HOLD, SQ_ACT, SQ_PRE, SQ_DONE} seq_t;
endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
  parameter int PERIOD = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R7
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (PERIOD == 1));
endmodule

// File: rtl/rfs_owed.sv
module rfs_owed #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pending,
  output logic overrun
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] FULL = W'(MAX);

  logic [W-1:0] owed;

  assign pending = (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed    <= '0;
      overrun <= 1'b0;
    end else if (tick && !take) begin
      if (owed == FULL) overrun <= 1'b1;
      else              owed    <= owed + 1'b1;
    end else if (take && !tick) begin
      owed <= owed - 1'b1;
    end
  end

  // R8
  owed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= FULL);
  // R8
  take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/rfs_strobe.sv
module rfs_strobe
  import rfs_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 2,
  parameter int T_RAS = 8,
  parameter int T_RP  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int CW = $clog2(T_CSR + T_RAS + T_RP + 1);
  localparam logic [CW-1:0] L_SETUP = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(T_CHR - 1);
  localparam logic [CW-1:0] L_ACT   = CW'(T_RAS - T_CHR - 1);
  localparam logic [CW-1:0] L_PRE   = CW'(T_RP - 1);

  seq_t          st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    case (st)
      SQ_SETUP: last = L_SETUP;
      SQ_HOLD:  last = L_HOLD;
      SQ_ACT:   last = L_ACT;
      default:  last = L_PRE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin st <= SQ_SETUP; cnt <= '0; end
        SQ_DONE: st <= SQ_IDLE;
        default: begin
          if (cnt == last) begin
            cnt <= '0;
            case (st)
              SQ_SETUP: st <= SQ_HOLD;
              SQ_HOLD:  st <= SQ_ACT;
              SQ_ACT:   st <= SQ_PRE;
              default:  st <= SQ_DONE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // strobes decoded straight from the state register
  assign idle  = (st == SQ_IDLE);
  assign done  = (st == SQ_DONE);
  assign cas_n = !(st == SQ_SETUP || st == SQ_HOLD);
  assign ras_n = !(st == SQ_HOLD || st == SQ_ACT);

  // R4
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n && $past(!cas_n));
  // R4
  cas_rises_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> !ras_n);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && idle);
endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
  import rfs_pkg::*;
#(
  parameter int INIT_WAIT      = 25000,
  parameter int INIT_REFRESHES = 8,
  parameter int REF_INTERVAL   = 1950,
  parameter int OWED_MAX       = 4,
  parameter int T_CSR          = 1,
  parameter int T_CHR          = 2,
  parameter int T_RAS          = 8,
  parameter int T_RP           = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_grant,
  output logic ref_req,
  output logic ref_done,
  output logic init_done,
  output logic overrun,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n
);
  localparam int BW = (INIT_REFRESHES > 1) ? $clog2(INIT_REFRESHES) : 1;
  localparam logic [BW-1:0] WAKE_LAST = BW'(INIT_REFRESHES - 1);

  phase_t        phase;
  logic [BW-1:0] wake_cnt;
  logic          wait_tick, run_tick, pending, seq_idle, take;

  rfs_interval #(.PERIOD(INIT_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_WAIT), .tick(wait_tick));

  rfs_interval #(.PERIOD(REF_INTERVAL)) u_period (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN), .tick(run_tick));

  rfs_owed #(.MAX(OWED_MAX)) u_owed (
    .clk(clk), .rst_n(rst_n), .tick(run_tick),
    .take(take && phase == PH_RUN), .pending(pending), .overrun(overrun));

  rfs_strobe #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(take), .idle(seq_idle), .done(ref_done),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n));

  assign ref_req   = seq_idle && (phase == PH_WAKE || (phase == PH_RUN && pending));
  assign take      = ref_req && ref_grant;
  assign init_done = (phase == PH_RUN);
  assign dram_we_n = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_WAIT;
      wake_cnt <= '0;
    end else begin
      case (phase)
        PH_WAIT: if (wait_tick) phase <= PH_WAKE;
        PH_WAKE: if (ref_done) begin
          if (wake_cnt == WAKE_LAST) phase <= PH_RUN;
          else                       wake_cnt <= wake_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R5
  req_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle |-> !ref_req);
  // R5
  grant_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> dram_ras_n);
  // R3
  stray_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && !ref_req && seq_idle) |=> dram_cas_n && dram_ras_n);
  // R6
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R2
  no_req_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |-> !ref_req && dram_ras_n);
endmodule

// File: tb/tb_rfs_sched.sv
module tb_rfs_sched;
  localparam int IW = 20, NW = 8, PI = 40, OM = 3;
  localparam int TCSR = 1, TCHR = 2, TRAS = 4, TRP = 2;
  localparam int L = TCSR + TRAS + TRP;

  logic clk = 0, rst_n = 0, ref_grant = 0;
  logic ref_req, ref_done, init_done, overrun, ras_n, cas_n, we_n;
  int   cyc = 0, checks = 0, errors = 0, d0 = 0;
  bit   finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  rfs_sched #(.INIT_WAIT(IW), .INIT_REFRESHES(NW), .REF_INTERVAL(PI), .OWED_MAX(OM),
              .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)) dut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_req(ref_req),
    .ref_done(ref_done), .init_done(init_done), .overrun(overrun),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n));

  task automatic chk(input string r, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // {req, done, ras_n, cas_n, we_n}
  function automatic int pins();
    return {ref_req, ref_done, ras_n, cas_n, we_n};
  endfunction

  task automatic serve(input string r, input bit poke);
    ref_grant = 1;
    @(negedge clk);
    ref_grant = 0;
    for (int i = 1; i <= L + 1; i++) begin
      int e;
      if (i > 1) @(negedge clk);
      if (i == 2) ref_grant = 0;
      if      (i <= TCSR)        e = 5'b00101;
      else if (i <= TCSR + TCHR) e = 5'b00001;
      else if (i <= TCSR + TRAS) e = 5'b00011;
      else if (i <= L)           e = 5'b00111;
      else                       e = 5'b01111;
      chk({r, "/R4"}, pins(), e, "strobe pattern");
      if (i == 1 && poke) ref_grant = 1;  // R5 grant while busy
    end
  endtask

  task automatic drain(input string r, output int n);
    n = 0;
    while (ref_req && n < 10) begin
      serve(r, 0);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", pins(), 5'b00111, "reset pins");
    chk("R1", {init_done, overrun}, 0, "reset flags");
    rst_n = 1;
    @(negedge clk);
    chk("R1", pins(), 5'b00111, "first cycle pins");
    chk("R1", {init_done, overrun}, 0, "first cycle flags");
    wait_to(5);
    ref_grant = 1;
    @(negedge clk);
    ref_grant = 0;
    chk("R3", pins(), 5'b00111, "stray grant, next cycle");
    @(negedge clk);
    chk("R3", pins(), 5'b00111, "stray grant, later cycle");
    wait_to(IW - 1);
    chk("R2", ref_req, 0, "request before wait ends");
    @(negedge clk);
    chk("R2", ref_req, 1, "request when wait ends");

    for (int b = 0; b < NW; b++) begin
      if (b > 0) @(negedge clk);
      repeat (b % 3) begin
        chk("R8", ref_req, 1, "wake request held");
        @(negedge clk);
      end
      chk("R6", init_done, 0, "init_done during wake-up");
      chk("R5", ref_req, 1, "request before grant");
      serve("R6", b == 2);
    end
    @(negedge clk);
    chk("R6", init_done, 1, "init_done after last wake refresh");
    chk("R6", ref_req, 0, "no request right after init");
    d0 = cyc;

    wait_to(d0 + PI - 1);
    chk("R7", ref_req, 0, "before first period");
    @(negedge clk);
    chk("R7", ref_req, 1, "first period");
    serve("R7", 1);
    wait_to(d0 + 2 * PI - 1);
    chk("R7", ref_req, 0, "before second period");
    @(negedge clk);
    chk("R7", ref_req, 1, "second period");
    repeat (15) @(negedge clk);
    chk("R7", ref_req, 1, "late grant, request held");
    serve("R7", 0);
    wait_to(d0 + 3 * PI - 1);
    chk("R7", ref_req, 0, "before third period");
    @(negedge clk);
    chk("R7", ref_req, 1, "third period not shifted by late grant");

    wait_to(d0 + 5 * PI);
    drain("R8", n);
    chk("R8", n, 3, "queued refreshes served");
    chk("R9", overrun, 0, "no overrun at exact limit");

    wait_to(d0 + 9 * PI - 1);
    chk("R9", overrun, 0, "before overflowing period");
    @(negedge clk);
    chk("R9", overrun, 1, "overrun on overflowing period");
    drain("R9", n);
    chk("R9", n, 3, "overflow adds no obligation");
    chk("R9", overrun, 1, "overrun sticky");
    chk("R9", init_done, 1, "init_done still high");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule